// File: doc/BRIEF.md
# Interleaved DRAM Range Decoder

This block steers a 40-bit physical memory request to one of eight destination nodes. It holds eight programmable regions. Each region has a base word and a limit word, and each region spans whole 16 MB units of address space. A region can allow reads, writes, both or neither. A region can also claim only every second, fourth or eighth 4 KB slice of its range, chosen by address bits 12 to 14. Several regions can therefore cover the same span and spread it across several nodes.

Software loads the regions through a single-cycle write strobe. Each write carries a region index, a base/limit selector and a 32-bit data word. Requests arrive on a valid/ready channel as an address plus a write flag. The answer leaves one cycle later on a second valid/ready channel and carries hit, miss and the destination node.

Back-pressure works as follows. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high whenever the response slot is empty or is being drained in that same cycle. Once a response is presented, it stays unchanged until the cycle in which `rsp_ready` is high.

Top module: `dram_route_decoder`

## Requirements
- R1: After reset, every region is disabled, `rsp_valid` is 0 and `req_ready` is 1. Any request made before programming returns a miss.
- R2: A region covers request addresses whose bits 39:24 lie between its base field and its limit field, with both ends included.
- R3: Base word bit 0 allows reads and bit 1 allows writes. A region never matches an operation whose enable bit is 0.
- R4: Base word bits 10:8 hold the interleave code. Code 000 compares no address bits. Code 001 compares A[12]. Code 011 compares A[13:12]. Code 111 compares A[14:12]. The compared bits must equal the same bits of the select field in limit word bits 10:8.
- R5: A region whose interleave code is 010, 100, 101 or 110 never matches.
- R6: On a hit, `rsp_node` carries limit word bits 2:0 of the matching region. On a miss, `rsp_hit` is 0, `rsp_miss` is 1 and `rsp_node` is 0.
- R7: When several regions match, the region with the lowest index supplies the node.
- R8: A configuration write takes effect for a request accepted on the same clock edge.
- R9: A request accepted on a clock edge produces its response, with `rsp_valid` high, right after that edge.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0 and the response fields stay unchanged. A request waiting during that time is accepted on the edge where `rsp_ready` returns high.
- R11: `cfg_sel_limit`=0 writes the base word of region `cfg_idx`, and 1 writes its limit word. Bits 31:16 of either word hold address bits 39:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Region index of the write |
| cfg_sel_limit | input | 1 | 0 = base word, 1 = limit word |
| cfg_wdata | input | 32 | Word written |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 40 | Physical address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer can take it |
| rsp_hit | output | 1 | A region matched |
| rsp_miss | output | 1 | No region matched |
| rsp_node | output | 3 | Destination node |

## Verification
A corrupted region field appears as a wrong node, or as a false hit or false miss, on the very next response for any address that the field governs. A field that no request touches stays hidden, so the vectors place addresses at range edges and at every interleave slot. A fault in the response slot shows up on the first stalled cycle, as a changed field or a request that is lost or duplicated. A broken write bypass is caught on the response that directly follows the combined write and request.

// File: rtl/dram_route_decoder_pkg.sv
package dram_route_decoder_pkg;
  localparam int NUM_REGIONS = 8;
  localparam int ADDR_W      = 40;
  localparam int NODE_W      = 3;
  localparam int GRAN_LSB    = 24;
  localparam int RANGE_W     = ADDR_W - GRAN_LSB;
  localparam int IL_LSB      = 12;
  localparam int IL_W        = 3;
  localparam int WORD_W      = 32;
  localparam int IDX_W       = $clog2(NUM_REGIONS);

  // Field positions inside configuration words
  localparam int F_RD_EN     = 0;
  localparam int F_WR_EN     = 1;
  localparam int F_IL_LSB    = 8;
  localparam int F_ADDR_LSB  = 16;
  localparam int F_NODE_LSB  = 0;

  typedef struct packed {
    logic [RANGE_W-1:0] base;
    logic [RANGE_W-1:0] limit;
    logic               rd_en;
    logic               wr_en;
    logic [IL_W-1:0]    il_code;
    logic [IL_W-1:0]    il_sel;
    logic [NODE_W-1:0]  node;
  } region_cfg_t;

  // Only contiguous low-bit masks are legal interleave codes
  function automatic logic il_code_legal(input logic [IL_W-1:0] code);
    logic [IL_W:0] plus1;
    plus1 = {1'b0, code} + 1'b1;
    return ((plus1 & {1'b0, code}) == '0);
  endfunction
endpackage

// File: rtl/dram_route_regfile.sv
module dram_route_regfile
  import dram_route_decoder_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic                cfg_sel_limit,
  input  logic [WORD_W-1:0]   cfg_wdata,
  output region_cfg_t         cfg_eff [NUM_REGIONS]
);
  region_cfg_t cfg_q [NUM_REGIONS];

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^{cfg_wdata[15:11], cfg_wdata[7:3]};

  genvar g;
  generate
    for (g = 0; g < NUM_REGIONS; g++) begin : g_reg
      logic hit_base, hit_limit;
      assign hit_base  = cfg_we && !cfg_sel_limit && (cfg_idx == IDX_W'(g));
      assign hit_limit = cfg_we &&  cfg_sel_limit && (cfg_idx == IDX_W'(g));

      region_cfg_t nxt;
      always_comb begin
        nxt = cfg_q[g];
        if (hit_base) begin
          nxt.base    = cfg_wdata[F_ADDR_LSB +: RANGE_W];
          nxt.rd_en   = cfg_wdata[F_RD_EN];
          nxt.wr_en   = cfg_wdata[F_WR_EN];
          nxt.il_code = cfg_wdata[F_IL_LSB +: IL_W];
        end
        if (hit_limit) begin
          nxt.limit  = cfg_wdata[F_ADDR_LSB +: RANGE_W];
          nxt.il_sel = cfg_wdata[F_IL_LSB +: IL_W];
          nxt.node   = cfg_wdata[F_NODE_LSB +: NODE_W];
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) cfg_q[g] <= '0;
        else        cfg_q[g] <= nxt;
      end

      // Write bypass: a lookup in the write cycle sees the new word
      assign cfg_eff[g] = nxt;
    end
  endgenerate
endmodule

// File: rtl/dram_route_region_match.sv
module dram_route_region_match
  import dram_route_decoder_pkg::*;
(
  input  region_cfg_t         cfg,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                is_write,
  output logic                match
);
  logic [RANGE_W-1:0] upper;
  logic [IL_W-1:0]    slot;
  logic               in_range, op_ok, il_ok;

  logic unused_addr_bits;
  assign unused_addr_bits = ^{addr[IL_LSB-1:0], addr[GRAN_LSB-1:IL_LSB+IL_W]};

  assign upper    = addr[ADDR_W-1:GRAN_LSB];
  assign slot     = addr[IL_LSB +: IL_W];
  assign in_range = (upper >= cfg.base) && (upper <= cfg.limit);
  assign op_ok    = is_write ? cfg.wr_en : cfg.rd_en;
  assign il_ok    = il_code_legal(cfg.il_code) &&
                    ((slot & cfg.il_code) == (cfg.il_sel & cfg.il_code));
  assign match    = in_range && op_ok && il_ok;
endmodule

// File: rtl/dram_route_prio.sv
module dram_route_prio
  import dram_route_decoder_pkg::*;
(
  input  logic [NUM_REGIONS-1:0]             match_vec,
  input  logic [NUM_REGIONS-1:0][NODE_W-1:0] node_vec,
  output logic                               any_hit,
  output logic [NODE_W-1:0]                  node
);
  always_comb begin
    any_hit = 1'b0;
    node    = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        any_hit = 1'b1;
        node    = node_vec[i];
      end
    end
  end
endmodule

// File: rtl/dram_route_decoder.sv
module dram_route_decoder
  import dram_route_decoder_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic                cfg_sel_limit,
  input  logic [WORD_W-1:0]   cfg_wdata,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_write,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_hit,
  output logic                rsp_miss,
  output logic [NODE_W-1:0]   rsp_node
);
  region_cfg_t                        cfg_eff [NUM_REGIONS];
  logic [NUM_REGIONS-1:0]             match_vec;
  logic [NUM_REGIONS-1:0][NODE_W-1:0] node_vec;
  logic                               dec_hit;
  logic [NODE_W-1:0]                  dec_node;

  dram_route_regfile u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_idx       (cfg_idx),
    .cfg_sel_limit (cfg_sel_limit),
    .cfg_wdata     (cfg_wdata),
    .cfg_eff       (cfg_eff)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_REGIONS; g++) begin : g_match
      dram_route_region_match u_match (
        .cfg      (cfg_eff[g]),
        .addr     (req_addr),
        .is_write (req_write),
        .match    (match_vec[g])
      );
      assign node_vec[g] = cfg_eff[g].node;
    end
  endgenerate

  dram_route_prio u_prio (
    .match_vec (match_vec),
    .node_vec  (node_vec),
    .any_hit   (dec_hit),
    .node      (dec_node)
  );

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_node  <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit  <= dec_hit;
        rsp_miss <= !dec_hit;
        rsp_node <= dec_hit ? dec_node : '0;
      end
    end
  end
endmodule

// File: rtl/dram_route_decoder_chk.sv
module dram_route_decoder_chk
  import dram_route_decoder_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic [NODE_W-1:0] rsp_node
);
  // R6
  hit_miss_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_miss));

  // R6
  miss_node_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_node == '0));

  // R9
  accept_gives_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R10
  stall_holds_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) &&
                                   $stable(rsp_miss) && $stable(rsp_node)));

  // R10
  stall_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind dram_route_decoder dram_route_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_hit   (rsp_hit),
  .rsp_miss  (rsp_miss),
  .rsp_node  (rsp_node)
);

// File: tb/dram_route_decoder_tb.sv
module dram_route_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic        cfg_sel_limit = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [39:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit, rsp_miss;
  logic [2:0]  rsp_node;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dram_route_decoder u_dut (.*);

  // {write, addr, exp_hit, exp_node}
  localparam logic [44:0] VEC [14] = '{
    {1'b0, 40'h0010000000, 1'b1, 3'd1},  // R2 R3 region0 read
    {1'b1, 40'h0010000000, 1'b1, 3'd1},  // R3 region0 write
    {1'b0, 40'h0100000000, 1'b1, 3'd2},  // R2 base edge
    {1'b1, 40'h0100000000, 1'b0, 3'd0},  // R3 write disabled
    {1'b0, 40'h01FFFFFFFF, 1'b1, 3'd2},  // R2 inclusive limit
    {1'b0, 40'h0200000000, 1'b1, 3'd3},  // R4 2-way A12=0
    {1'b0, 40'h0200001000, 1'b1, 3'd4},  // R4 2-way A12=1
    {1'b1, 40'h02FF00F000, 1'b1, 3'd4},  // R4 A12=1 upper bits ignored
    {1'b0, 40'h0300000000, 1'b1, 3'd5},  // R4 4-way slot0
    {1'b0, 40'h0300002000, 1'b1, 3'd7},  // R4 4-way slot2
    {1'b0, 40'h0300003000, 1'b1, 3'd0},  // R4 4-way slot3 node0
    {1'b0, 40'h0300005000, 1'b1, 3'd6},  // R4 A14 ignored
    {1'b0, 40'h0400000000, 1'b0, 3'd0},  // R6 miss
    {1'b0, 40'hFFFFFFFFFF, 1'b0, 3'd0}   // R6 miss top
  };

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input bit lim, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_sel_limit = lim; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] bw(input logic [15:0] a, input logic [2:0] code,
                                     input bit we, input bit re);
    return {a, 5'd0, code, 6'd0, we, re};
  endfunction

  function automatic logic [31:0] lw(input logic [15:0] a, input logic [2:0] sel,
                                     input logic [2:0] node);
    return {a, 5'd0, sel, 5'd0, node};
  endfunction

  task automatic lookup(input string rq, input bit wr, input logic [39:0] a,
                        input bit eh, input logic [2:0] en);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk({rq, " valid"}, 64'(rsp_valid), 64'(1));
    chk({rq, " hit"},   64'(rsp_hit),   64'(eh));
    chk({rq, " miss"},  64'(rsp_miss),  64'(!eh));
    chk({rq, " node"},  64'(rsp_node),  64'(en));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", 64'(rsp_valid), 64'(0));
    chk("R1 req_ready", 64'(req_ready), 64'(1));
    rst_n = 1'b1;
    lookup("R1 unprogrammed", 1'b0, 40'h0010000000, 1'b0, 3'd0);

    // R11 programming: limit before base
    cfg(0, 1, lw(16'h00FF, 3'd0, 3'd1)); cfg(0, 0, bw(16'h0000, 3'b000, 1, 1));
    cfg(1, 1, lw(16'h01FF, 3'd0, 3'd2)); cfg(1, 0, bw(16'h0100, 3'b000, 0, 1));
    cfg(2, 1, lw(16'h02FF, 3'd0, 3'd3)); cfg(2, 0, bw(16'h0200, 3'b001, 1, 1));
    cfg(3, 1, lw(16'h02FF, 3'd1, 3'd4)); cfg(3, 0, bw(16'h0200, 3'b001, 1, 1));
    for (int i = 0; i < 4; i++) begin
      cfg(4 + i, 1, lw(16'h03FF, 3'(i), 3'((5 + i) % 8)));
      cfg(4 + i, 0, bw(16'h0300, 3'b011, 1, 1));
    end

    for (int v = 0; v < 14; v++) begin
      lookup($sformatf("R2/R3/R4/R6 vec%0d", v), VEC[v][44], VEC[v][43:4],
             VEC[v][3], VEC[v][2:0]);
    end

    // R5 reserved code on region1
    cfg(1, 0, bw(16'h0100, 3'b010, 1, 1));
    lookup("R5 reserved code", 1'b0, 40'h0100000000, 1'b0, 3'd0);
    // R4 8-way with select 5
    cfg(1, 1, lw(16'h01FF, 3'd5, 3'd2));
    cfg(1, 0, bw(16'h0100, 3'b111, 1, 1));
    lookup("R4 8-way slot5", 1'b0, 40'h0100005000, 1'b1, 3'd2);
    lookup("R4 8-way slot4", 1'b0, 40'h0100004000, 1'b0, 3'd0);
    // R7 overlap: region1 over region0 span
    cfg(1, 1, lw(16'h00FF, 3'd0, 3'd2));
    cfg(1, 0, bw(16'h0000, 3'b000, 1, 1));
    lookup("R7 lower index wins", 1'b0, 40'h0010000000, 1'b1, 3'd1);
    cfg(0, 0, 32'h0);
    lookup("R7 next region", 1'b0, 40'h0010000000, 1'b1, 3'd2);

    // R8 bypass: re-enable region0 in the request cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd0; cfg_sel_limit = 1'b0;
    cfg_wdata = bw(16'h0000, 3'b000, 1, 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 40'h0010000000;
    @(posedge clk); #1;
    cfg_we = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    chk("R8 bypass node", 64'(rsp_node), 64'(1));

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 40'h0200001000;
    @(posedge clk); #1;
    req_addr = 40'h0300002000;
    @(negedge clk);
    chk("R9 valid after accept", 64'(rsp_valid), 64'(1));
    chk("R10 req_ready low", 64'(req_ready), 64'(0));
    @(posedge clk);
    @(negedge clk);
    chk("R10 held node", 64'(rsp_node), 64'(4));
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10 waiting request node", 64'(rsp_node), 64'(7));
    @(posedge clk);
    @(negedge clk);
    chk("R9 slot drains", 64'(rsp_valid), 64'(0));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule